// File: doc/BRIEF.md
# Two-Wire Bus Master Transfer Sequencer

This block drives master-mode transfers for a two-wire serial bus controller. A host programs a control word (enable, master, direction, start, stop, repeat and a 10-bit-address flag), a 7-bit target address and a byte count, then moves data through a transmit byte queue and a receive byte queue. The sequencer talks to a byte-level bus engine through a one-command-per-cycle interface: start-with-address, send byte, receive byte and end transfer. The engine answers each command in the same cycle with an acknowledge flag or a received byte, and it reports whether the bus is held.

The sequencer has two modes. In counted mode the live count falls by one per byte moved. When it reaches zero, the sequencer either ends the transfer (stop set) or raises access-ready and drops the master bit (stop clear). In repeat mode the count is left untouched: the sequencer drains the transmit queue or keeps the receive queue full until the host sets stop. Any refused acknowledge raises the nack event, clears stop and halts data movement.

Top module: `i2c_mxfer_seq`

## Requirements
- R1: After reset the control word, live count, nack, access-ready and transmit-ready flags and both queue levels are zero, and no bus command is issued.
- R2: A control write keeps only the bits of mask 0xCF87. No start is issued unless enable (bit 15) and master (bit 10) are set and the 10-bit flag (bit 8) is clear.
- R3: With enable, master and start (bit 0) set, a start command to the target address follows in the next cycle. It reads when transmit (bit 9) is clear. The start bit self-clears and both queues are emptied.
- R4: A refused start sets the nack flag, clears stop (bit 1), moves no data and leaves the live count unchanged. An acknowledged start loads the live count from the count register.
- R5: In counted transmit mode, queued bytes are sent oldest first, at most one per cycle, each decrementing the live count. Transmit-ready is high while the count is nonzero, the last send was acknowledged and the queue is empty.
- R6: In counted receive mode, bytes are received while the count is nonzero and fewer than 4 are queued, each decrementing the count. Receive-ready is high exactly when at least one byte is queued, and the host pops bytes in arrival order.
- R7: When the count reaches zero with stop set, an end command is issued, stop clears, the live count reloads from the count register and queued transmit bytes are dropped.
- R8: When the count reaches zero with stop clear, access-ready is set, master clears and no end command is issued.
- R9: In repeat mode (bit 2) the count is neither checked nor changed. Transmit drains the queue and then raises transmit-ready, receive keeps 4 bytes queued, and stop ends the transfer at the next step.
- R10: A refused data byte sets the nack flag, clears stop and halts sending; bytes still queued are not sent.
- R11: No command other than start is issued while the bus-busy input is low. A host data write to a full transmit queue (4 bytes) is ignored.
- R12: The live count is visible at the port at all times. A status-clear write (select 4) clears nack with data bit 1 and access-ready with data bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Write target: 0 control, 1 address, 2 count, 3 data byte, 4 status clear |
| host_wdata | input | 16 | Host write data |
| host_pop | input | 1 | Pop one byte from the receive queue |
| ctrl_rd | output | 16 | Current control word |
| live_count | output | CNT_W | Remaining byte count |
| rx_byte | output | 8 | Oldest received byte |
| rx_level | output | LVL_W | Bytes in the receive queue |
| stat_nack | output | 1 | Nack event flag |
| stat_ardy | output | 1 | Access-ready event flag |
| stat_xrdy | output | 1 | Transmit-ready |
| stat_rrdy | output | 1 | Receive-ready |
| bus_cmd_valid | output | 1 | A bus command is issued this cycle |
| bus_cmd_op | output | 2 | Command: 0 start, 1 send, 2 receive, 3 end |
| bus_addr | output | SADDR_W | Target address for start |
| bus_rnw | output | 1 | Start direction, 1 = read |
| bus_wbyte | output | 8 | Byte to send |
| bus_ack | input | 1 | Same-cycle acknowledge for start or send |
| bus_rbyte | input | 8 | Same-cycle received byte |
| bus_busy | input | 1 | Bus held by this master |

## Verification
Two situations are hard to reach from the ports. The first is a transmit queue that overflows while the sequencer is live: the sequencer empties the queue as fast as the host fills it. The bench therefore holds the bus-busy input low after an acknowledged start, writes five bytes, then releases the bus and counts exactly four sends. The second is a nack in the middle of a transfer: the bus model refuses one chosen byte index, so the bench can check that the halt leaves one queued byte unsent and the count mid-way.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_END   = 2'd3
    } bus_op_e;

    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_SADDR = 3'd1;
    localparam logic [2:0] SEL_COUNT = 3'd2;
    localparam logic [2:0] SEL_DATA  = 3'd3;
    localparam logic [2:0] SEL_STAT  = 3'd4;

    localparam logic [15:0] CTRL_MASK = 16'hCF87;
    localparam int B_EN  = 15;
    localparam int B_MST = 10;
    localparam int B_TRX = 9;
    localparam int B_XA  = 8;
    localparam int B_RM  = 2;
    localparam int B_STP = 1;
    localparam int B_STT = 0;
endpackage

// File: rtl/seq_byte_fifo.sv
module seq_byte_fifo #(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic             pop,
    output logic [7:0]       dout,
    output logic [LVL_W-1:0] level
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      rd;
        logic [PTR_W-1:0]      wr;
        logic [LVL_W-1:0]      lvl;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_pop, do_push;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d     = f_q;
        do_pop  = pop && (f_q.lvl != '0);
        do_push = push && ((f_q.lvl != LVL_W'(DEPTH)) || do_pop);
        if (flush) begin
            f_d.rd  = '0;
            f_d.wr  = '0;
            f_d.lvl = '0;
        end else begin
            if (do_push) begin
                f_d.mem[f_q.wr] = din;
                f_d.wr          = ptr_inc(f_q.wr);
            end
            if (do_pop) begin
                f_d.rd = ptr_inc(f_q.rd);
            end
            f_d.lvl = f_q.lvl + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign dout  = f_q.mem[f_q.rd];
    assign level = f_q.lvl;

    // R6
    fifo_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
endmodule

// File: rtl/i2c_mxfer_seq.sv
module i2c_mxfer_seq
    import seq_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 16,
    parameter int SADDR_W    = 7,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [2:0]         host_sel,
    input  logic [15:0]        host_wdata,
    input  logic               host_pop,
    output logic [15:0]        ctrl_rd,
    output logic [CNT_W-1:0]   live_count,
    output logic [7:0]         rx_byte,
    output logic [LVL_W-1:0]   rx_level,
    output logic               stat_nack,
    output logic               stat_ardy,
    output logic               stat_xrdy,
    output logic               stat_rrdy,
    output logic               bus_cmd_valid,
    output logic [1:0]         bus_cmd_op,
    output logic [SADDR_W-1:0] bus_addr,
    output logic               bus_rnw,
    output logic [7:0]         bus_wbyte,
    input  logic               bus_ack,
    input  logic [7:0]         bus_rbyte,
    input  logic               bus_busy
);
    typedef struct packed {
        logic [15:0]        ctrl;
        logic [SADDR_W-1:0] saddr;
        logic [CNT_W-1:0]   count;
        logic [CNT_W-1:0]   live;
        logic               xfer;
        logic               nack;
        logic               ardy;
        logic               xrdy;
    } seq_t;

    seq_t             s_d, s_q;
    logic             start_go;
    logic [CNT_W-1:0] live_m1;
    logic             tx_push, tx_pop, tx_flush;
    logic             rx_push, rx_flush;
    logic [7:0]       tx_dout;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    bus_op_e          op_c;

    seq_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push),
        .din(host_wdata[7:0]), .pop(tx_pop), .dout(tx_dout), .level(tx_lvl)
    );

    seq_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push),
        .din(bus_rbyte), .pop(host_pop), .dout(rx_byte), .level(rx_lvl)
    );

    always_comb begin
        s_d           = s_q;
        bus_cmd_valid = 1'b0;
        op_c          = OP_START;
        tx_pop        = 1'b0;
        tx_flush      = 1'b0;
        rx_push       = 1'b0;
        rx_flush      = 1'b0;
        live_m1       = s_q.live - 1'b1;
        start_go      = s_q.ctrl[B_EN] && s_q.ctrl[B_MST] &&
                        !s_q.ctrl[B_XA] && s_q.ctrl[B_STT];

        if (start_go) begin
            bus_cmd_valid    = 1'b1;
            op_c             = OP_START;
            s_d.ctrl[B_STT]  = 1'b0;
            tx_flush         = 1'b1;
            rx_flush         = 1'b1;
            if (bus_ack) begin
                s_d.live = s_q.count;
                s_d.xfer = 1'b1;
            end else begin
                s_d.nack        = 1'b1;
                s_d.ctrl[B_STP] = 1'b0;
                s_d.xfer        = 1'b0;
            end
        end else if (s_q.xfer && bus_busy) begin
            if (s_q.ctrl[B_STP] && (s_q.ctrl[B_RM] || s_q.live == '0)) begin
                // stop: close the transfer
                bus_cmd_valid   = 1'b1;
                op_c            = OP_END;
                s_d.ctrl[B_STP] = 1'b0;
                s_d.live        = s_q.count;
                tx_flush        = 1'b1;
                s_d.xfer        = 1'b0;
                s_d.xrdy        = 1'b0;
            end else if (!s_q.ctrl[B_RM] && s_q.live == '0) begin
                s_d.ardy         = 1'b1;
                s_d.ctrl[B_MST]  = 1'b0;
                s_d.xfer         = 1'b0;
                s_d.xrdy         = 1'b0;
            end else if (s_q.ctrl[B_TRX]) begin
                if (tx_lvl != '0) begin
                    bus_cmd_valid = 1'b1;
                    op_c          = OP_SEND;
                    tx_pop        = 1'b1;
                    if (!s_q.ctrl[B_RM]) begin
                        s_d.live = live_m1;
                    end
                    if (bus_ack) begin
                        s_d.xrdy = s_q.ctrl[B_RM] ? (tx_lvl == LVL_W'(1))
                                                  : (live_m1 != '0);
                    end else begin
                        s_d.nack        = 1'b1;
                        s_d.ctrl[B_STP] = 1'b0;
                        s_d.xfer        = 1'b0;
                        s_d.xrdy        = 1'b0;
                    end
                end else begin
                    s_d.xrdy = 1'b1;
                end
            end else if (rx_lvl != LVL_W'(FIFO_DEPTH)) begin
                bus_cmd_valid = 1'b1;
                op_c          = OP_RECV;
                rx_push       = 1'b1;
                if (!s_q.ctrl[B_RM]) begin
                    s_d.live = live_m1;
                end
            end
        end

        tx_push = host_we && (host_sel == SEL_DATA);
        if (host_we) begin
            case (host_sel)
                SEL_CTRL:  s_d.ctrl  = host_wdata & CTRL_MASK;
                SEL_SADDR: s_d.saddr = host_wdata[SADDR_W-1:0];
                SEL_COUNT: s_d.count = CNT_W'(host_wdata);
                SEL_STAT: begin
                    if (host_wdata[1]) s_d.nack = 1'b0;
                    if (host_wdata[2]) s_d.ardy = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_cmd_op = op_c;
    assign bus_addr   = s_q.saddr;
    assign bus_rnw    = !s_q.ctrl[B_TRX];
    assign bus_wbyte  = tx_dout;
    assign ctrl_rd    = s_q.ctrl;
    assign live_count = s_q.live;
    assign rx_level   = rx_lvl;
    assign stat_nack  = s_q.nack;
    assign stat_ardy  = s_q.ardy;
    assign stat_xrdy  = s_q.xrdy;
    assign stat_rrdy  = (rx_lvl != '0);

    // R11
    no_cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_cmd_op != OP_START) |-> bus_busy);

    // R5
    send_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_cmd_op == OP_SEND) |-> (tx_lvl != '0));

    // R3
    stt_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_go && !(host_we && host_sel == SEL_CTRL)) |=> !ctrl_rd[B_STT]);

    // R8
    ardy_drops_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stat_ardy) && !$past(host_we)) |-> !ctrl_rd[B_MST]);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && (bus_cmd_op == OP_SEND || bus_cmd_op == OP_RECV) && !ctrl_rd[B_RM])
        |=> (live_count == $past(live_count) - 1'b1));
endmodule

// File: tb/i2c_mxfer_seq_tb.sv
module i2c_mxfer_seq_tb;
    import seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [15:0] host_wdata = '0;
    logic        host_pop = 1'b0;
    logic [15:0] ctrl_rd;
    logic [15:0] live_count;
    logic [7:0]  rx_byte;
    logic [2:0]  rx_level;
    logic        stat_nack, stat_ardy, stat_xrdy, stat_rrdy;
    logic        bus_cmd_valid;
    logic [1:0]  bus_cmd_op;
    logic [6:0]  bus_addr;
    logic        bus_rnw;
    logic [7:0]  bus_wbyte;
    logic        bus_ack, bus_busy;
    logic [7:0]  bus_rbyte;

    always #10 clk = ~clk;

    i2c_mxfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_pop(host_pop), .ctrl_rd(ctrl_rd),
        .live_count(live_count), .rx_byte(rx_byte), .rx_level(rx_level),
        .stat_nack(stat_nack), .stat_ardy(stat_ardy), .stat_xrdy(stat_xrdy),
        .stat_rrdy(stat_rrdy), .bus_cmd_valid(bus_cmd_valid), .bus_cmd_op(bus_cmd_op),
        .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_wbyte(bus_wbyte),
        .bus_ack(bus_ack), .bus_rbyte(bus_rbyte), .bus_busy(bus_busy)
    );

    // bus engine model
    logic       busy_m, hold_idle, nack_start;
    int         nack_at, xidx;
    int         n_start, n_end, n_send, n_recv;
    logic [7:0] sent_log [0:31];
    logic [7:0] rx_next;
    logic [6:0] last_addr;
    logic       last_rnw;

    assign bus_busy  = busy_m & ~hold_idle;
    assign bus_ack   = (bus_cmd_op == OP_START) ? ~nack_start : (xidx != nack_at);
    assign bus_rbyte = rx_next;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_m <= 1'b0; xidx <= 0; n_start <= 0; n_end <= 0;
            n_send <= 0; n_recv <= 0; rx_next <= 8'h30;
        end else if (bus_cmd_valid) begin
            case (bus_cmd_op)
                OP_START: begin
                    n_start <= n_start + 1; busy_m <= ~nack_start; xidx <= 0;
                    last_addr <= bus_addr; last_rnw <= bus_rnw;
                end
                OP_SEND: begin
                    sent_log[n_send[4:0]] <= bus_wbyte;
                    n_send <= n_send + 1; xidx <= xidx + 1;
                end
                OP_RECV: begin
                    n_recv <= n_recv + 1; rx_next <= rx_next + 8'd1;
                end
                default: begin
                    n_end <= n_end + 1; busy_m <= 1'b0;
                end
            endcase
        end
    end

    int total = 0;
    int fails = 0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic pop_byte(output int b);
        @(negedge clk);
        b = rx_byte; host_pop = 1'b1;
        @(negedge clk);
        host_pop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {transmit, count[2:0], stop}
    localparam logic [4:0] VEC [4] = '{5'b00111, 5'b00100, 5'b10110, 5'b10101};

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int s0, e0, snd0, r0, b;
        logic [7:0] seed;
        hold_idle = 1'b0; nack_start = 1'b0; nack_at = -1;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1
        chk("R1 ctrl", ctrl_rd, 0);
        chk("R1 live", live_count, 0);
        chk("R1 flags", {stat_nack, stat_ardy, stat_xrdy, stat_rrdy}, 0);
        chk("R1 rx level", rx_level, 0);
        chk("R1 no command", n_start + n_send + n_recv + n_end, 0);

        // R2: mask and 10-bit refusal, then enable clear
        s0 = n_start;
        wr(SEL_CTRL, 16'hFFFF);
        idle(4);
        chk("R2 mask", ctrl_rd, 16'hCF87);
        chk("R2 xa no start", n_start - s0, 0);
        wr(SEL_CTRL, 16'h0401);
        idle(4);
        chk("R2 enable clear no start", n_start - s0, 0);

        // R4: refused start
        nack_start = 1'b1;
        wr(SEL_COUNT, 16'd5);
        wr(SEL_CTRL, 16'h8403);
        idle(4);
        chk("R4 nack flag", stat_nack, 1);
        chk("R4 stop and start cleared", ctrl_rd, 16'h8400);
        chk("R4 live unchanged", live_count, 0);
        chk("R4 no data", n_send + n_recv, 0);
        nack_start = 1'b0;
        wr(SEL_STAT, 16'h0002);
        idle(1);
        chk("R12 nack cleared", stat_nack, 0);

        // table of counted transfers
        for (int v = 0; v < 4; v++) begin
            logic trx, stp;
            int cnt;
            trx = VEC[v][4]; cnt = int'(VEC[v][3:1]); stp = VEC[v][0];
            wr(SEL_STAT, 16'h0006);
            wr(SEL_SADDR, 16'h0150 + 16'(v));
            wr(SEL_COUNT, 16'(cnt));
            s0 = n_start; e0 = n_end; snd0 = n_send; seed = rx_next;
            wr(SEL_CTRL, 16'h8401 | (16'(trx) << 9) | (16'(stp) << 1));
            idle(3);
            chk("R3 one start", n_start - s0, 1);
            chk("R3 address", last_addr, 7'h50 + 7'(v));
            chk("R3 direction", last_rnw, !trx);
            if (trx) begin
                chk("R5 xrdy waiting", stat_xrdy, 1);
                for (int i = 0; i < cnt; i++) wr(SEL_DATA, 16'h00A0 + 16'(16 * v + i));
                idle(8);
                chk("R5 send count", n_send - snd0, cnt);
                for (int i = 0; i < cnt; i++)
                    chk("R5 byte order", sent_log[snd0 + i], 8'hA0 + 8'(16 * v + i));
            end else begin
                idle(6);
                chk("R6 rrdy", stat_rrdy, 1);
                chk("R6 level", rx_level, cnt);
                for (int i = 0; i < cnt; i++) begin
                    pop_byte(b);
                    chk("R6 pop order", b, int'(seed) + i);
                end
                chk("R6 rrdy low when empty", stat_rrdy, 0);
            end
            chk("R7 stop cleared", ctrl_rd[1], 0);
            if (stp) begin
                chk("R7 end issued", n_end - e0, 1);
                chk("R7 live reloaded", live_count, cnt);
                chk("R7 no ardy", stat_ardy, 0);
            end else begin
                chk("R8 ardy", stat_ardy, 1);
                chk("R8 master cleared", ctrl_rd[10], 0);
                chk("R8 no end", n_end - e0, 0);
                chk("R12 live zero", live_count, 0);
            end
        end

        // R8: count zero at start
        wr(SEL_STAT, 16'h0006);
        wr(SEL_COUNT, 16'd0);
        r0 = n_recv;
        wr(SEL_CTRL, 16'h8401);
        idle(4);
        chk("R8 zero count ardy", stat_ardy, 1);
        chk("R8 zero count no receive", n_recv - r0, 0);
        wr(SEL_STAT, 16'h0004);
        idle(1);
        chk("R12 ardy cleared", stat_ardy, 0);

        // R10: nack on second data byte
        wr(SEL_COUNT, 16'd4);
        nack_at = 1;
        snd0 = n_send; e0 = n_end;
        wr(SEL_CTRL, 16'h8603);
        idle(2);
        for (int i = 0; i < 3; i++) wr(SEL_DATA, 16'h00C0 + 16'(i));
        idle(6);
        chk("R10 nack flag", stat_nack, 1);
        chk("R10 sends halted", n_send - snd0, 2);
        chk("R10 stop cleared", ctrl_rd[1], 0);
        chk("R10 live mid-way", live_count, 2);
        chk("R10 no end", n_end - e0, 0);
        nack_at = -1;
        wr(SEL_STAT, 16'h0006);

        // R11: bus idle holds movement, full queue drops extra byte
        wr(SEL_COUNT, 16'd6);
        hold_idle = 1'b1;
        snd0 = n_send;
        wr(SEL_CTRL, 16'h8601);
        for (int i = 0; i < 5; i++) wr(SEL_DATA, 16'h00D0 + 16'(i));
        idle(4);
        chk("R11 no send while idle", n_send - snd0, 0);
        hold_idle = 1'b0;
        idle(8);
        chk("R11 overflow ignored", n_send - snd0, 4);
        chk("R11 last sent byte", sent_log[snd0 + 3], 8'hD3);
        chk("R12 live after four", live_count, 2);
        chk("R5 xrdy with count left", stat_xrdy, 1);

        // R9: repeat receive
        wr(SEL_COUNT, 16'd2);
        r0 = n_recv; e0 = n_end;
        wr(SEL_CTRL, 16'h8405);
        idle(8);
        chk("R9 receive fills queue", rx_level, 4);
        chk("R9 count ignored", live_count, 2);
        pop_byte(b);
        idle(3);
        chk("R9 refill after pop", n_recv - r0, 5);
        chk("R9 level kept full", rx_level, 4);
        wr(SEL_CTRL, 16'h8406);
        idle(3);
        chk("R9 stop ends", n_end - e0, 1);
        chk("R9 stop cleared", ctrl_rd[1], 0);

        // R9: repeat transmit
        wr(SEL_COUNT, 16'd1);
        snd0 = n_send;
        wr(SEL_CTRL, 16'h8605);
        idle(2);
        for (int i = 0; i < 3; i++) wr(SEL_DATA, 16'h00E0 + 16'(i));
        idle(5);
        chk("R9 transmit drains past count", n_send - snd0, 3);
        chk("R9 transmit count untouched", live_count, 1);
        chk("R9 xrdy after drain", stat_xrdy, 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule